// File: doc/BRIEF.md
# Indexed Sample-Channel Register Interface

This block is the byte-wide host side of an eight-voice sample player. A host writes one channel's parameters at a time: it first chooses a channel in the control register, and later writes to the small set of internal offsets land in that channel's envelope, pan, step, loop-start and start registers. The same control register can instead choose which 4 KB page of a 64 KB wave memory is seen through the host window at 0x1000–0x1FFF. The choice depends on one bit of the written byte. Every write to the control register also sets the global enable.

The channel on/off register is active-low. Turning a channel off, or writing the start address of a channel that is already off, sends a one-cycle reload request to the playback engine. The engine then reloads that channel's playback pointer from its start value. Host reads return either bytes from the wave memory window or the integer part of a channel's current playback address, which the engine supplies. All parameter registers are presented to the engine as flat vectors. The mixing arithmetic is handled elsewhere.

Top module: `sample_reg_hub`

## Requirements
- R1: After reset, every pan byte is 0xFF. Every envelope, step, loop-start and start value is 0. The channel index, the bank, the global enable, `chanOn`, `reloadReq` and `hostRdData` are all 0.
- R2: Internal write offsets 0, 1, 2, 3, 4 and 5 set, in the indexed channel only, these fields: envelope, pan, step bits [7:0], step bits [15:8], loop-start bits [7:0] and loop-start bits [15:8]. The other channels are not changed.
- R3: A write to offset 7 always copies data bit 7 to `globalEnable`. If data bit 6 is 1, data bits [2:0] become the channel index and the bank is unchanged. If data bit 6 is 0, data bits [3:0] become the bank and the index is unchanged.
- R4: A write to offset 6 stores the data byte as the indexed channel's start value. If that channel is off at the time of the write, its bit of `reloadReq` is 1 for exactly the one cycle after the write. If the channel is on, `reloadReq` stays 0.
- R5: A write to offset 8 sets `chanOn` to the bitwise inverse of the data. For exactly the one cycle after the write, `reloadReq` equals the data.
- R6: A write anywhere in 0x1000–0x1FFF drives `memWrEn` high in that same cycle, with `memAddr` = {bank, hostAddr[11:0]} and `memWrData` = the data. No register changes.
- R7: A read in 0x1000–0x1FFF puts the `memRdData` value seen at `memAddr` = {bank, hostAddr[11:0]} on `hostRdData` after the next clock edge.
- R8: A read at 0x10–0x1F returns data from channel (hostAddr >> 1) & 7. An even address gives bits [7:0] of that channel's `playAddrFlat` entry, and an odd address gives bits [15:8].
- R9: A read of any other internal address returns 0xFF. A write to any internal address other than 0–8 (for example 0x009 or 0x100) changes nothing.
- R10: `hostRdData` keeps its value in cycles without a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostAddr | input | 13 | Host byte address |
| hostWrEn | input | 1 | Host write strobe |
| hostRdEn | input | 1 | Host read strobe |
| hostWrData | input | 8 | Host write byte |
| hostRdData | output | 8 | Registered host read byte |
| memAddr | output | 16 | Wave memory address {bank, window offset} |
| memWrEn | output | 1 | Wave memory write enable |
| memWrData | output | 8 | Wave memory write byte |
| memRdData | input | 8 | Wave memory read byte (asynchronous read) |
| playAddrFlat | input | 128 | Integer playback address per channel, 16 bits each |
| globalEnable | output | 1 | Global play enable |
| chanOn | output | 8 | Channel running flags (1 = on) |
| reloadReq | output | 8 | One-cycle pointer reload requests |
| envFlat | output | 64 | Envelope per channel, 8 bits each |
| panFlat | output | 64 | Pan per channel, 8 bits each |
| stepFlat | output | 128 | Step per channel, 16 bits each |
| loopFlat | output | 128 | Loop start per channel, 16 bits each |
| startFlat | output | 64 | Start byte per channel, 8 bits each |

## Verification
Results come due at different times. The window write port is combinational, so `memWrEn`, `memAddr` and `memWrData` are checked inside the write cycle, before the clock edge. Every register, `chanOn`, `hostRdData` and the reload pulse changes at the first edge after the access. The bench drives each access on a falling edge and samples at the next falling edge. For the reload pulse it samples once more one cycle later, which shows that the pulse lasts exactly one cycle.

// File: rtl/sample_reg_pkg.sv
package sample_reg_pkg;
  localparam int OFS_ENV     = 0;
  localparam int OFS_PAN     = 1;
  localparam int OFS_STEP_LO = 2;
  localparam int OFS_STEP_HI = 3;
  localparam int OFS_LOOP_LO = 4;
  localparam int OFS_LOOP_HI = 5;
  localparam int OFS_START   = 6;
  localparam int OFS_CTRL    = 7;
  localparam int OFS_ONOFF   = 8;
  localparam int RD_PTR_BASE = 16;
  localparam int RD_PTR_END  = 32;
  localparam int CTRL_SEL_BIT = 6;
  localparam int CTRL_EN_BIT  = 7;

  typedef struct packed {
    logic wrEnv;
    logic wrPan;
    logic wrStepLo;
    logic wrStepHi;
    logic wrLoopLo;
    logic wrLoopHi;
    logic wrStart;
    logic wrCtrl;
    logic wrOnOff;
    logic wrMem;
    logic rdMem;
    logic rdPtr;
    logic rdNone;
  } regStrobes_t;
endpackage

// File: rtl/sample_reg_ctrl.sv
module sample_reg_ctrl
  import sample_reg_pkg::*;
#(
  parameter int WIN_AW = 12,
  localparam int HOST_AW = WIN_AW + 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [HOST_AW-1:0] hostAddr,
  input  logic               hostWrEn,
  input  logic               hostRdEn,
  output regStrobes_t        stb
);
  logic              inWindow;
  logic [WIN_AW-1:0] ofs;

  assign inWindow = hostAddr[WIN_AW];
  assign ofs      = hostAddr[WIN_AW-1:0];

  always_comb begin
    stb = '0;
    if (hostWrEn) begin
      if (inWindow) stb.wrMem = 1'b1;
      else begin
        case (ofs)
          WIN_AW'(OFS_ENV):     stb.wrEnv    = 1'b1;
          WIN_AW'(OFS_PAN):     stb.wrPan    = 1'b1;
          WIN_AW'(OFS_STEP_LO): stb.wrStepLo = 1'b1;
          WIN_AW'(OFS_STEP_HI): stb.wrStepHi = 1'b1;
          WIN_AW'(OFS_LOOP_LO): stb.wrLoopLo = 1'b1;
          WIN_AW'(OFS_LOOP_HI): stb.wrLoopHi = 1'b1;
          WIN_AW'(OFS_START):   stb.wrStart  = 1'b1;
          WIN_AW'(OFS_CTRL):    stb.wrCtrl   = 1'b1;
          WIN_AW'(OFS_ONOFF):   stb.wrOnOff  = 1'b1;
          default: ;
        endcase
      end
    end
    if (hostRdEn) begin
      if (inWindow) stb.rdMem = 1'b1;
      else if (ofs >= WIN_AW'(RD_PTR_BASE) && ofs < WIN_AW'(RD_PTR_END)) stb.rdPtr = 1'b1;
      else stb.rdNone = 1'b1;
    end
  end

  // R9
  undefined_wr_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (hostWrEn && !inWindow && ofs > WIN_AW'(OFS_ONOFF)) |->
      !(stb.wrEnv || stb.wrPan || stb.wrStepLo || stb.wrStepHi || stb.wrLoopLo ||
        stb.wrLoopHi || stb.wrStart || stb.wrCtrl || stb.wrOnOff || stb.wrMem));

  // R2
  one_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.wrEnv, stb.wrPan, stb.wrStepLo, stb.wrStepHi, stb.wrLoopLo,
              stb.wrLoopHi, stb.wrStart, stb.wrCtrl, stb.wrOnOff, stb.wrMem}));
endmodule

// File: rtl/sample_reg_dp.sv
module sample_reg_dp
  import sample_reg_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int DATA_W = 8,
  parameter int WIN_AW = 12,
  parameter int BANK_W = 4,
  parameter int PLAY_W = 16,
  localparam int IDX_W  = $clog2(NUM_CH),
  localparam int STEP_W = 2 * DATA_W,
  localparam int MEM_AW = BANK_W + WIN_AW
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  regStrobes_t              stb,
  input  logic [WIN_AW-1:0]        hostOfs,
  input  logic [DATA_W-1:0]        hostWrData,
  output logic [DATA_W-1:0]        hostRdData,
  output logic [MEM_AW-1:0]        memAddr,
  output logic                     memWrEn,
  output logic [DATA_W-1:0]        memWrData,
  input  logic [DATA_W-1:0]        memRdData,
  input  logic [NUM_CH*PLAY_W-1:0] playAddrFlat,
  output logic                     globalEnable,
  output logic [NUM_CH-1:0]        chanOn,
  output logic [NUM_CH-1:0]        reloadReq,
  output logic [NUM_CH*DATA_W-1:0] envFlat,
  output logic [NUM_CH*DATA_W-1:0] panFlat,
  output logic [NUM_CH*STEP_W-1:0] stepFlat,
  output logic [NUM_CH*STEP_W-1:0] loopFlat,
  output logic [NUM_CH*DATA_W-1:0] startFlat
);
  logic [DATA_W-1:0] envR   [NUM_CH];
  logic [DATA_W-1:0] panR   [NUM_CH];
  logic [STEP_W-1:0] stepR  [NUM_CH];
  logic [STEP_W-1:0] loopR  [NUM_CH];
  logic [DATA_W-1:0] startR [NUM_CH];
  logic [PLAY_W-1:0] playAddr [NUM_CH];
  logic [IDX_W-1:0]  chanIdx;
  logic [BANK_W-1:0] bankSel;
  logic [IDX_W-1:0]  ptrSel;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_flat
    assign envFlat[i*DATA_W +: DATA_W]   = envR[i];
    assign panFlat[i*DATA_W +: DATA_W]   = panR[i];
    assign stepFlat[i*STEP_W +: STEP_W]  = stepR[i];
    assign loopFlat[i*STEP_W +: STEP_W]  = loopR[i];
    assign startFlat[i*DATA_W +: DATA_W] = startR[i];
    assign playAddr[i] = playAddrFlat[i*PLAY_W +: PLAY_W];
  end

  assign memAddr   = {bankSel, hostOfs};
  assign memWrEn   = stb.wrMem;
  assign memWrData = hostWrData;
  assign ptrSel    = hostOfs[IDX_W:1];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_CH; i++) begin
        envR[i]   <= '0;
        panR[i]   <= '1;
        stepR[i]  <= '0;
        loopR[i]  <= '0;
        startR[i] <= '0;
      end
      chanIdx      <= '0;
      bankSel      <= '0;
      globalEnable <= 1'b0;
      chanOn       <= '0;
      reloadReq    <= '0;
      hostRdData   <= '0;
    end else begin
      reloadReq <= '0;
      if (stb.wrEnv)    envR[chanIdx] <= hostWrData;
      if (stb.wrPan)    panR[chanIdx] <= hostWrData;
      if (stb.wrStepLo) stepR[chanIdx][DATA_W-1:0]      <= hostWrData;
      if (stb.wrStepHi) stepR[chanIdx][STEP_W-1:DATA_W] <= hostWrData;
      if (stb.wrLoopLo) loopR[chanIdx][DATA_W-1:0]      <= hostWrData;
      if (stb.wrLoopHi) loopR[chanIdx][STEP_W-1:DATA_W] <= hostWrData;
      if (stb.wrStart) begin
        startR[chanIdx] <= hostWrData;
        if (!chanOn[chanIdx]) reloadReq[chanIdx] <= 1'b1;
      end
      if (stb.wrCtrl) begin
        if (hostWrData[CTRL_SEL_BIT]) chanIdx <= hostWrData[IDX_W-1:0];
        else bankSel <= hostWrData[BANK_W-1:0];
        globalEnable <= hostWrData[CTRL_EN_BIT];
      end
      if (stb.wrOnOff) begin
        chanOn    <= ~hostWrData[NUM_CH-1:0];
        reloadReq <= hostWrData[NUM_CH-1:0];
      end
      if (stb.rdMem) hostRdData <= memRdData;
      else if (stb.rdPtr)
        hostRdData <= hostOfs[0] ? playAddr[ptrSel][PLAY_W-1:PLAY_W-DATA_W]
                                 : playAddr[ptrSel][DATA_W-1:0];
      else if (stb.rdNone) hostRdData <= '1;
    end
  end

  // R4
  start_off_reload_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.wrStart && !chanOn[chanIdx]) |=> reloadReq[$past(chanIdx)]);

  // R4
  start_on_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.wrStart && chanOn[chanIdx]) |=> (reloadReq == '0));

  // R5
  onoff_inverse_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.wrOnOff |=> (chanOn == ~$past(hostWrData[NUM_CH-1:0])));

  // R5
  reload_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reloadReq != '0) |-> $past(stb.wrStart || stb.wrOnOff));

  // R3
  bank_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.wrCtrl && hostWrData[CTRL_SEL_BIT]) |=> $stable(bankSel));

  // R10
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(stb.rdMem || stb.rdPtr || stb.rdNone) |=> $stable(hostRdData));
endmodule

// File: rtl/sample_reg_hub.sv
module sample_reg_hub
  import sample_reg_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic [12:0]  hostAddr,
  input  logic         hostWrEn,
  input  logic         hostRdEn,
  input  logic [7:0]   hostWrData,
  output logic [7:0]   hostRdData,
  output logic [15:0]  memAddr,
  output logic         memWrEn,
  output logic [7:0]   memWrData,
  input  logic [7:0]   memRdData,
  input  logic [127:0] playAddrFlat,
  output logic         globalEnable,
  output logic [7:0]   chanOn,
  output logic [7:0]   reloadReq,
  output logic [63:0]  envFlat,
  output logic [63:0]  panFlat,
  output logic [127:0] stepFlat,
  output logic [127:0] loopFlat,
  output logic [63:0]  startFlat
);
  regStrobes_t stb;

  sample_reg_ctrl #(.WIN_AW(12)) u_ctrl (
    .clk(clk), .rstN(rstN), .hostAddr(hostAddr),
    .hostWrEn(hostWrEn), .hostRdEn(hostRdEn), .stb(stb)
  );

  sample_reg_dp #(.NUM_CH(8), .DATA_W(8), .WIN_AW(12), .BANK_W(4), .PLAY_W(16)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .hostOfs(hostAddr[11:0]),
    .hostWrData(hostWrData), .hostRdData(hostRdData),
    .memAddr(memAddr), .memWrEn(memWrEn), .memWrData(memWrData), .memRdData(memRdData),
    .playAddrFlat(playAddrFlat), .globalEnable(globalEnable), .chanOn(chanOn),
    .reloadReq(reloadReq), .envFlat(envFlat), .panFlat(panFlat),
    .stepFlat(stepFlat), .loopFlat(loopFlat), .startFlat(startFlat)
  );

  // R6
  mem_window_chk: assert property (@(posedge clk) disable iff (!rstN)
    memWrEn |-> (hostAddr[12] && hostWrEn && memAddr[11:0] == hostAddr[11:0]));
endmodule

// File: tb/sample_reg_hub_tb.sv
`timescale 1ns/1ps
module sample_reg_hub_tb;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [12:0]  hostAddr = '0;
  logic         hostWrEn = 1'b0;
  logic         hostRdEn = 1'b0;
  logic [7:0]   hostWrData = '0;
  logic [7:0]   hostRdData;
  logic [15:0]  memAddr;
  logic         memWrEn;
  logic [7:0]   memWrData;
  logic [7:0]   memRdData;
  logic [127:0] playAddrFlat;
  logic         globalEnable;
  logic [7:0]   chanOn, reloadReq;
  logic [63:0]  envFlat, panFlat, startFlat;
  logic [127:0] stepFlat, loopFlat;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  function automatic logic [7:0] memModel(input logic [15:0] a);
    return a[15:8] ^ a[7:0] ^ 8'h3C;
  endfunction

  function automatic logic [15:0] playModel(input int ch);
    return 16'(ch * 16'h1357) ^ 16'hB1C0;
  endfunction

  assign memRdData = memModel(memAddr);
  for (genvar i = 0; i < 8; i++) begin : g_play
    assign playAddrFlat[i*16 +: 16] = playModel(i);
  end

  sample_reg_hub u_dut (.*);

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic hostWrite(input logic [12:0] a, input logic [7:0] d);
    @(negedge clk);
    hostAddr = a; hostWrData = d; hostWrEn = 1'b1;
    @(negedge clk);
    hostWrEn = 1'b0;
  endtask

  task automatic hostRead(input logic [12:0] a, output logic [7:0] d);
    @(negedge clk);
    hostAddr = a; hostRdEn = 1'b1;
    @(negedge clk);
    hostRdEn = 1'b0;
    d = hostRdData;
  endtask

  task automatic testReset();
    for (int i = 0; i < 8; i++) begin
      chk(panFlat[i*8 +: 8] == 8'hFF, "R1 pan", panFlat[i*8 +: 8], 8'hFF);
      chk(envFlat[i*8 +: 8] == 8'h00, "R1 env", envFlat[i*8 +: 8], 0);
    end
    chk(stepFlat == '0 && loopFlat == '0 && startFlat == '0, "R1 step/loop/start", stepFlat[31:0], 0);
    chk(chanOn == 0 && reloadReq == 0 && !globalEnable, "R1 status", {chanOn, reloadReq}, 0);
    chk(hostRdData == 0, "R1 rddata", hostRdData, 0);
  endtask

  task automatic testChanRegs();
    hostWrite(13'h007, 8'h43);
    for (int k = 0; k < 6; k++) hostWrite(13'(k), 8'((k + 1) * 8'h11));
    chk(envFlat[24 +: 8] == 8'h11, "R2 env ch3", envFlat[24 +: 8], 8'h11);
    chk(panFlat[24 +: 8] == 8'h22, "R2 pan ch3", panFlat[24 +: 8], 8'h22);
    chk(stepFlat[48 +: 16] == 16'h4433, "R2 step ch3", stepFlat[48 +: 16], 16'h4433);
    chk(loopFlat[48 +: 16] == 16'h6655, "R2 loop ch3", loopFlat[48 +: 16], 16'h6655);
    chk(panFlat[16 +: 8] == 8'hFF && envFlat[16 +: 8] == 0, "R2 ch2 untouched", {panFlat[16 +: 8], envFlat[16 +: 8]}, 16'hFF00);
    chk(!globalEnable, "R3 enable from bit7=0", globalEnable, 0);
  endtask

  task automatic testCtrl();
    hostWrite(13'h007, 8'h85);
    chk(globalEnable, "R3 enable from bank write", globalEnable, 1);
    hostWrite(13'h007, 8'hC6);
    @(negedge clk);
    hostAddr = 13'h1234;
    #1 chk(memAddr == 16'h5234, "R3 bank kept on index write", memAddr, 16'h5234);
    hostWrite(13'h000, 8'h9D);
    chk(envFlat[48 +: 8] == 8'h9D, "R3 index 6 selected", envFlat[48 +: 8], 8'h9D);
    chk(envFlat[24 +: 8] == 8'h11, "R3 index 6 ch3 kept", envFlat[24 +: 8], 8'h11);
    hostWrite(13'h007, 8'h47);
    chk(!globalEnable, "R3 enable cleared", globalEnable, 0);
  endtask

  task automatic testOnOff();
    hostWrite(13'h008, 8'hF0);
    chk(chanOn == 8'h0F, "R5 chanOn inverse", chanOn, 8'h0F);
    chk(reloadReq == 8'hF0, "R5 reload pulse", reloadReq, 8'hF0);
    @(negedge clk);
    chk(reloadReq == 8'h00, "R5 pulse one cycle", reloadReq, 0);
  endtask

  task automatic testStart();
    hostWrite(13'h007, 8'h41);
    hostWrite(13'h006, 8'h9A);
    chk(startFlat[8 +: 8] == 8'h9A, "R4 start ch1", startFlat[8 +: 8], 8'h9A);
    chk(reloadReq == 0, "R4 on channel no reload", reloadReq, 0);
    hostWrite(13'h007, 8'h45);
    hostWrite(13'h006, 8'h3C);
    chk(startFlat[40 +: 8] == 8'h3C, "R4 start ch5", startFlat[40 +: 8], 8'h3C);
    chk(reloadReq == 8'h20, "R4 off channel reload", reloadReq, 8'h20);
    @(negedge clk);
    chk(reloadReq == 0, "R4 pulse one cycle", reloadReq, 0);
  endtask

  task automatic testWindow();
    logic [7:0] d;
    logic [63:0] envSnap;
    envSnap = envFlat;
    hostWrite(13'h007, 8'h0A);
    @(negedge clk);
    hostAddr = 13'h1ABC; hostWrData = 8'h5E; hostWrEn = 1'b1;
    #1 chk(memWrEn && memAddr == 16'hAABC && memWrData == 8'h5E, "R6 window write",
           {memWrEn, memAddr, memWrData}, {1'b1, 16'hAABC, 8'h5E});
    @(negedge clk);
    hostWrEn = 1'b0;
    #1 chk(!memWrEn, "R6 write strobe drops", memWrEn, 0);
    chk(envFlat == envSnap && chanOn == 8'h0F, "R6 no register change", chanOn, 8'h0F);
    hostRead(13'h1003, d);
    chk(d == memModel(16'hA003), "R7 window read", d, memModel(16'hA003));
    repeat (3) @(negedge clk);
    chk(hostRdData == memModel(16'hA003), "R10 read data held", hostRdData, memModel(16'hA003));
  endtask

  task automatic testPtrRead();
    logic [7:0] d, e;
    for (int a = 16; a < 32; a++) begin
      hostRead(13'(a), d);
      e = a[0] ? playModel((a >> 1) & 7)[15:8] : playModel((a >> 1) & 7)[7:0];
      chk(d == e, "R8 pointer read", d, e);
    end
  endtask

  task automatic testUndefined();
    logic [7:0] d;
    hostRead(13'h009, d);
    chk(d == 8'hFF, "R9 read 0x009", d, 8'hFF);
    hostRead(13'h020, d);
    chk(d == 8'hFF, "R9 read 0x020", d, 8'hFF);
    hostWrite(13'h009, 8'h00);
    chk(chanOn == 8'h0F && reloadReq == 0, "R9 write 0x009 ignored", chanOn, 8'h0F);
    hostWrite(13'h100, 8'h77);
    chk(envFlat[40 +: 8] == 8'h00, "R9 write 0x100 ignored", envFlat[40 +: 8], 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testChanRegs();
    testCtrl();
    testOnOff();
    testStart();
    testWindow();
    testPtrRead();
    testUndefined();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule